// File: doc/BRIEF.md
# Greedy double-base (2,3) encoder

This block turns an unsigned binary integer into a sparse sum of terms of the form 2^i·3^j. The terms are chosen greedily. The encoder keeps a remainder that starts at the input value. On each step it picks the largest number of that form that is not above the remainder, emits its two exponents and subtracts it from the remainder. It stops once the remainder is zero.

A client pulses `start` with a value on `valueIn`. The exponent pairs then come out on consecutive cycles, each one marked by `termValid`. A one-cycle `done` marks the end of the conversion, and `termCount` reports how many terms were produced. The term search is a parallel grid of compare-against-remainder candidates, so every term costs exactly one cycle.

Top module: `dbn_greedy_enc`

## Requirements
- R1: Each emitted term stands for the value (1 << expTwo) * 3^expThree. Here expTwo is in 0..DATA_W-1, expThree is in 0..J_MAX, and the value fits in DATA_W bits.
- R2: Each emitted term is the largest value of the form 2^i·3^j that does not exceed the current remainder. The remainder equals the input value minus all terms already emitted in this conversion.
- R3: The terms of one conversion add up exactly to the input value, and emission stops when the remainder reaches zero.
- R4: The first term appears in the cycle right after `start` is accepted. The remaining terms follow on consecutive cycles with `termValid` high, one term per cycle. There is no term in the cycle after `done`.
- R5: `done` is a single-cycle pulse. It coincides with the last term. For an input of zero it is asserted alone, with no term, in the cycle after `start`.
- R6: Within a conversion, each term's value is strictly smaller than that of the term before it.
- R7: `termCount` is cleared when `start` is accepted and rises by one after every cycle that carries a term. It holds the total after `done` until the next accepted `start`.
- R8: `start` and `valueIn` are ignored from the cycle after an accepted `start` up to and including the `done` cycle. A conversion finishes with the terms of its own input.
- R9: After reset, `termValid` and `done` are low and `termCount` is zero.
- R10: Input 54 yields the single term (1,3). Input 14 yields (2,1) then (1,0). Input 20 yields (1,2) then (1,0). Each pair is written as (expTwo, expThree).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a conversion when the block is idle |
| valueIn | input | DATA_W | Value to encode, sampled with an accepted start |
| termValid | output | 1 | Marks a term on expTwo/expThree |
| expTwo | output | $clog2(DATA_W) | Exponent of 2 of the current term |
| expThree | output | $clog2(J_MAX+1) | Exponent of 3 of the current term |
| done | output | 1 | One-cycle end-of-conversion pulse |
| termCount | output | CNT_W | Terms emitted so far in the current conversion |

## Verification
The bench builds the encoder with its defaults: DATA_W=16, J_MAX=10 and CNT_W=5. With these values the whole ladder of powers of three up to 59049 and every shift up to 15 lie within the input range. The inputs 65535, 32768 and 59049 therefore reach the corners of the candidate grid, zero reaches the empty conversion, and random values drive multi-term chains where each step's remainder shrinks below the previous term.

// File: rtl/dbn_pkg.sv
package dbn_pkg;

  typedef struct packed {
    logic load;
    logic step;
  } dbnCtrl_t;

  typedef enum logic {ST_IDLE, ST_RUN} dbnState_t;

  function automatic logic [63:0] pow3(input int n);
    logic [63:0] p;
    p = 64'd1;
    for (int k = 0; k < n; k++) p = p * 64'd3;
    return p;
  endfunction

endpackage

// File: rtl/dbn_term_search.sv
module dbn_term_search #(
  parameter int DATA_W = 16,
  parameter int J_MAX  = 10,
  localparam int ITW   = $clog2(DATA_W),
  localparam int JTW   = $clog2(J_MAX + 1)
) (
  input  logic [DATA_W-1:0] rem,
  output logic [ITW-1:0]    bestI,
  output logic [JTW-1:0]    bestJ,
  output logic [DATA_W-1:0] bestVal
);
  localparam int W2 = 2 * DATA_W;
  localparam int NJ = J_MAX + 1;

  logic [NJ-1:0]     rowHit;
  logic [ITW-1:0]    rowI   [NJ];
  logic [DATA_W-1:0] rowVal [NJ];
  logic [W2-1:0]     remWide;

  assign remWide = {{DATA_W{1'b0}}, rem};

  // one row per power of three: largest shift that still fits
  for (genvar j = 0; j < NJ; j++) begin : gRow
    localparam logic [W2-1:0] BASE = W2'(dbn_pkg::pow3(j));
    logic              hit;
    logic [ITW-1:0]    iSel;
    logic [DATA_W-1:0] val;
    always_comb begin
      hit  = 1'b0;
      iSel = '0;
      val  = '0;
      for (int i = 0; i < DATA_W; i++) begin
        if ((BASE << i) <= remWide) begin
          hit  = 1'b1;
          iSel = ITW'(i);
          val  = DATA_W'(BASE << i);
        end
      end
    end
    assign rowHit[j] = hit;
    assign rowI[j]   = iSel;
    assign rowVal[j] = val;
  end

  // across rows: strict compare keeps the smaller j on equal values
  always_comb begin
    bestVal = '0;
    bestI   = '0;
    bestJ   = '0;
    for (int j = 0; j < NJ; j++) begin
      if (rowHit[j] && (rowVal[j] > bestVal)) begin
        bestVal = rowVal[j];
        bestI   = rowI[j];
        bestJ   = JTW'(j);
      end
    end
  end
endmodule

// File: rtl/dbn_datapath.sv
module dbn_datapath #(
  parameter int DATA_W = 16,
  parameter int J_MAX  = 10,
  parameter int CNT_W  = 5,
  localparam int ITW   = $clog2(DATA_W),
  localparam int JTW   = $clog2(J_MAX + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  dbn_pkg::dbnCtrl_t  ctrl,
  input  logic [DATA_W-1:0]  valueIn,
  output logic               remZero,
  output logic               lastTerm,
  output logic [ITW-1:0]     expTwo,
  output logic [JTW-1:0]     expThree,
  output logic [CNT_W-1:0]   termCount
);
  logic [DATA_W-1:0] remReg;
  logic [DATA_W-1:0] termVal;
  logic [DATA_W-1:0] nextRem;
  logic [CNT_W-1:0]  cntReg;

  dbn_term_search #(.DATA_W(DATA_W), .J_MAX(J_MAX)) uSearch (
    .rem    (remReg),
    .bestI  (expTwo),
    .bestJ  (expThree),
    .bestVal(termVal)
  );

  assign nextRem   = remReg - termVal;
  assign remZero   = (remReg == '0);
  assign lastTerm  = !remZero && (nextRem == '0);
  assign termCount = cntReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remReg <= '0;
      cntReg <= '0;
    end else if (ctrl.load) begin
      remReg <= valueIn;
      cntReg <= '0;
    end else if (ctrl.step) begin
      remReg <= nextRem;
      cntReg <= cntReg + CNT_W'(1);
    end
  end
endmodule

// File: rtl/dbn_control.sv
module dbn_control (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              remZero,
  input  logic              lastTerm,
  output dbn_pkg::dbnCtrl_t ctrl,
  output logic              termValid,
  output logic              done
);
  dbn_pkg::dbnState_t state, nextState;

  always_comb begin
    ctrl      = '0;
    termValid = 1'b0;
    done      = 1'b0;
    nextState = state;
    case (state)
      dbn_pkg::ST_IDLE: begin
        if (start) begin
          ctrl.load = 1'b1;
          nextState = dbn_pkg::ST_RUN;
        end
      end
      default: begin
        if (remZero) begin
          done      = 1'b1;
          nextState = dbn_pkg::ST_IDLE;
        end else begin
          ctrl.step = 1'b1;
          termValid = 1'b1;
          if (lastTerm) begin
            done      = 1'b1;
            nextState = dbn_pkg::ST_IDLE;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= dbn_pkg::ST_IDLE;
    else       state <= nextState;
  end
endmodule

// File: rtl/dbn_greedy_enc.sv
module dbn_greedy_enc #(
  parameter int DATA_W = 16,
  parameter int J_MAX  = 10,
  parameter int CNT_W  = 5,
  localparam int ITW   = $clog2(DATA_W),
  localparam int JTW   = $clog2(J_MAX + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [DATA_W-1:0] valueIn,
  output logic              termValid,
  output logic [ITW-1:0]    expTwo,
  output logic [JTW-1:0]    expThree,
  output logic              done,
  output logic [CNT_W-1:0]  termCount
);
  dbn_pkg::dbnCtrl_t ctrl;
  logic remZero;
  logic lastTerm;

  dbn_control uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .remZero  (remZero),
    .lastTerm (lastTerm),
    .ctrl     (ctrl),
    .termValid(termValid),
    .done     (done)
  );

  dbn_datapath #(.DATA_W(DATA_W), .J_MAX(J_MAX), .CNT_W(CNT_W)) uData (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .valueIn  (valueIn),
    .remZero  (remZero),
    .lastTerm (lastTerm),
    .expTwo   (expTwo),
    .expThree (expThree),
    .termCount(termCount)
  );
endmodule

// File: rtl/dbn_greedy_enc_chk.sv
module dbn_greedy_enc_chk #(
  parameter int DATA_W = 16,
  parameter int J_MAX  = 10,
  parameter int CNT_W  = 5,
  localparam int ITW   = $clog2(DATA_W),
  localparam int JTW   = $clog2(J_MAX + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic             termValid,
  input logic [ITW-1:0]   expTwo,
  input logic [JTW-1:0]   expThree,
  input logic             done,
  input logic [CNT_W-1:0] termCount
);
  localparam int W2 = 2 * DATA_W;
  logic [W2-1:0] termVal;

  assign termVal = W2'(dbn_pkg::pow3(int'(expThree))) << expTwo;

  AST_TERM_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    termValid |-> ((int'(expThree) <= J_MAX) && ((termVal >> DATA_W) == '0) && (termVal != '0))); // R1
  AST_TERM_SHRINKS: assert property (@(posedge clk) disable iff (!rstN)
    (termValid && $past(termValid)) |-> (termVal < $past(termVal))); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R5
  AST_QUIET_AFTER_DONE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !termValid); // R4
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    termValid |=> (termCount == $past(termCount) + CNT_W'(1))); // R7
  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!termValid && !start) |=> $stable(termCount)); // R7
endmodule

bind dbn_greedy_enc dbn_greedy_enc_chk #(
  .DATA_W(DATA_W), .J_MAX(J_MAX), .CNT_W(CNT_W)
) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .start    (start),
  .termValid(termValid),
  .expTwo   (expTwo),
  .expThree (expThree),
  .done     (done),
  .termCount(termCount)
);

// File: tb/dbn_greedy_enc_test.sv
`timescale 1ns/1ps
module dbn_greedy_enc_test;
  localparam int DATA_W = 16;
  localparam int J_MAX  = 10;
  localparam int CNT_W  = 5;
  localparam int ITW    = $clog2(DATA_W);
  localparam int JTW    = $clog2(J_MAX + 1);

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              start = 1'b0;
  logic [DATA_W-1:0] valueIn = '0;
  logic              termValid;
  logic [ITW-1:0]    expTwo;
  logic [JTW-1:0]    expThree;
  logic              done;
  logic [CNT_W-1:0]  termCount;

  int checks = 0;
  int failures = 0;
  int gotI[$];
  int gotJ[$];

  always #2.5 clk = ~clk;

  dbn_greedy_enc #(.DATA_W(DATA_W), .J_MAX(J_MAX), .CNT_W(CNT_W)) uut (
    .clk(clk), .rstN(rstN), .start(start), .valueIn(valueIn),
    .termValid(termValid), .expTwo(expTwo), .expThree(expThree),
    .done(done), .termCount(termCount)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint termOf(input int i, input int j);
    longint p = 1;
    for (int k = 0; k < j; k++) p = p * 3;
    return p << i;
  endfunction

  // behavioural greedy model, one conversion compared cycle by cycle
  task automatic runConv(input int v, input bit noisy);
    int expI[$];
    int expJ[$];
    longint rem = v;
    longint sum = 0;
    longint prev = 0;
    int last;
    while (rem > 0) begin
      longint best = 0;
      int bi = 0;
      int bj = 0;
      for (int j = 0; j <= J_MAX; j++)
        for (int i = 0; i < DATA_W; i++)
          if (termOf(i, j) <= rem && termOf(i, j) > best) begin
            best = termOf(i, j); bi = i; bj = j;
          end
      expI.push_back(bi);
      expJ.push_back(bj);
      rem -= best;
    end
    gotI.delete();
    gotJ.delete();
    @(negedge clk);
    start = 1'b1;
    valueIn = DATA_W'(v);
    @(negedge clk);
    start = noisy;
    valueIn = noisy ? DATA_W'(v ^ 16'h5a5a) : DATA_W'(v);
    if (expI.size() == 0) begin
      check(termValid == 1'b0, "R5 zero input gives no term", termValid, 0);
      check(done == 1'b1, "R5 zero input done", done, 1);
    end
    last = expI.size() - 1;
    for (int k = 0; k <= last; k++) begin
      check(termValid == 1'b1, "R4 term each cycle", termValid, 1);
      check(int'(expTwo) == expI[k] && int'(expThree) == expJ[k], "R2 greedy exponents",
            int'(expTwo) * 100 + int'(expThree), expI[k] * 100 + expJ[k]);
      check(done == (k == last), "R5 done with last term", done, (k == last));
      check(int'(termCount) == k, "R7 running count", termCount, k);
      check(int'(expThree) <= J_MAX, "R1 exponent range", expThree, J_MAX);
      gotI.push_back(int'(expTwo));
      gotJ.push_back(int'(expThree));
      sum += termOf(int'(expTwo), int'(expThree));
      if (k > 0)
        check(termOf(int'(expTwo), int'(expThree)) < prev, "R6 strictly shrinking",
              termOf(int'(expTwo), int'(expThree)), prev);
      prev = termOf(int'(expTwo), int'(expThree));
      if (k < last) @(negedge clk);
    end
    start = 1'b0;
    @(negedge clk);
    check(termValid == 1'b0 && done == 1'b0, "R4 quiet after done", {termValid, done}, 0);
    check(int'(termCount) == expI.size(), "R7 final count", termCount, expI.size());
    check(sum == v, noisy ? "R8 busy start ignored, sum" : "R3 terms sum to input", sum, v);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL R4 watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(termValid == 1'b0, "R9 reset termValid", termValid, 0);
    check(done == 1'b0, "R9 reset done", done, 0);
    check(termCount == '0, "R9 reset count", termCount, 0);

    runConv(54, 1'b0);
    check(gotI.size() == 1 && gotI[0] == 1 && gotJ[0] == 3, "R10 54 -> (1,3)",
          gotI.size(), 1);
    runConv(14, 1'b0);
    check(gotI.size() == 2 && gotI[0] == 2 && gotJ[0] == 1 && gotI[1] == 1 && gotJ[1] == 0,
          "R10 14 -> (2,1),(1,0)", gotI.size(), 2);
    runConv(20, 1'b1);
    check(gotI.size() == 2 && gotI[0] == 1 && gotJ[0] == 2 && gotI[1] == 1 && gotJ[1] == 0,
          "R10 R8 20 -> (1,2),(1,0) with busy start", gotI.size(), 2);
    runConv(0, 1'b0);
    runConv(0, 1'b1);
    runConv(1, 1'b0);
    runConv(65535, 1'b0);
    runConv(65535, 1'b1);
    runConv(32768, 1'b0);
    runConv(59049, 1'b0);
    runConv(65534, 1'b1);
    for (int n = 0; n < 60; n++) runConv(int'($urandom_range(65535, 0)), n[0]);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule